// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Block

This block is the programming face of a multichannel DMA controller. It sits on a simple 32-bit request/response bus and decodes a 4 KB window. The window holds a small set of global words and, per channel, five 32-bit words: source address, destination address, link item, control and configuration. A separate transfer engine performs the data movement. That engine reads the channel-enable and controller-enable levels from this block. It gets a one-cycle kick whenever software rewrites a configuration word. It returns terminal-count and error set pulses, one bit per channel.

The interrupt enables have no registers of their own. Each channel's terminal-count enable is bit 15 of its configuration word, and its error enable is bit 14. The block keeps raw terminal-count and error bits. It masks them with those enables and drives three registered interrupt levels: error, terminal count, and their OR. The channel count is a parameter, 2 or 8, and it changes the first identification byte.

Top module: `dma_regblk`

## Requirements
- R1: After synchronous reset, every register, raw interrupt bit, the kick output and all interrupt outputs are zero, so status words at 0x000, 0x014 and 0x030 read 0.
- R2: A channel word lives at offset 0x100 + 0x20*channel + 4*slot. The slots are 0 source, 1 destination, 2 link, 3 control and 4 configuration. Writes store all 32 bits, and a read returns the stored value on `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R3: A channel slot above 4, a channel index at or above the channel count, an unused global word (0x038 to 0x0FC) and the range 0x200 to 0xFDF all read as zero, and writes to them change no register.
- R4: A high bit in `tc_set` or `err_set` sets the matching raw bit. The raw terminal-count bits read at 0x014 and the raw error bits at 0x018, with channel n at bit n.
- R5: Writing 0x008 clears each raw terminal-count bit whose position is 1 in the data, and writing 0x010 does the same for error bits. A set pulse in the same cycle as a clear of the same bit leaves the bit set.
- R6: The terminal-count mask bit of channel n is bit 15 of its configuration word, and its error mask bit is bit 14. Masked terminal-count status reads at 0x004, masked error status at 0x00C, and their bitwise OR at 0x000.
- R7: `irq_tc` is the OR of the masked terminal-count bits and `irq_err` the OR of the masked error bits, both registered one cycle after the raw bits and masks. `irq_any` is their OR.
- R8: Bit 0 of each configuration word enables that channel. It drives `chan_en[n]` and bit n of the word at 0x01C. The global configuration at 0x030 and the sync word at 0x034 are 32-bit read/write, and bit 0 of the global configuration drives `ctrl_en`.
- R9: The eight words from 0xFE0 to 0xFFC read the bytes 0x80 (8 channels) or 0x81 (2 channels), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05 and 0xB1 in bits 7:0.
- R10: A write to a valid channel configuration word or to 0x030 raises `kick` for exactly one cycle, in the cycle after the write. No other access raises it.
- R11: The four software request words 0x020 to 0x02C read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| tc_set | input | NCH | Terminal-count set pulses from the engine |
| err_set | input | NCH | Error set pulses from the engine |
| chan_en | output | NCH | Per-channel enable bits |
| ctrl_en | output | 1 | Controller enable |
| kick | output | 1 | One-cycle pulse after a configuration write |
| irq_err | output | 1 | Masked error interrupt |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_any | output | 1 | OR of both interrupts |

## Verification
Channel words are written with distinct patterns across different channels and slots, so a decode that swaps channel and slot fields or drops a bit returns a wrong word. Set pulses are applied both to channels whose configuration enables the mask and to channels whose configuration does not. This separates raw from masked status and shows that the interrupt outputs follow only the enabled bits. A clear issued in the same cycle as a set pulse on the same bit shows whether set or clear wins. Reads of reserved, slot-5, software-request and identification offsets expose any decode that aliases them onto live storage.

// File: rtl/dma_regblk_pkg.sv
package dma_regblk_pkg;
  localparam int DW = 32;
  localparam int AW = 12;

  typedef enum logic [2:0] {
    SLOT_SRC  = 3'd0,
    SLOT_DST  = 3'd1,
    SLOT_LINK = 3'd2,
    SLOT_CTRL = 3'd3,
    SLOT_CONF = 3'd4
  } slot_e;

  localparam int NSLOT = 5;

  // global word indices (byte offset >> 2)
  localparam logic [9:0] GW_STAT    = 10'd0;
  localparam logic [9:0] GW_TC_STAT = 10'd1;
  localparam logic [9:0] GW_TC_CLR  = 10'd2;
  localparam logic [9:0] GW_ER_STAT = 10'd3;
  localparam logic [9:0] GW_ER_CLR  = 10'd4;
  localparam logic [9:0] GW_TC_RAW  = 10'd5;
  localparam logic [9:0] GW_ER_RAW  = 10'd6;
  localparam logic [9:0] GW_ENMAP   = 10'd7;
  localparam logic [9:0] GW_GCONF   = 10'd12;
  localparam logic [9:0] GW_SYNC    = 10'd13;

  localparam int CONF_EN_BIT  = 0;
  localparam int CONF_ERM_BIT = 14;
  localparam int CONF_TCM_BIT = 15;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    id_byte = (nch == 2) ? 8'h81 : 8'h80;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regblk_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [2:0]     wr_chan,
  input  logic [2:0]     wr_slot,
  input  logic [DW-1:0]  wr_data,
  input  logic [2:0]     rd_chan,
  input  logic [2:0]     rd_slot,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] chan_en,
  output logic [NCH-1:0] tc_mask,
  output logic [NCH-1:0] err_mask
);
  logic [DW-1:0] words [NCH][NSLOT];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)
          words[c][s] <= '0;
        else if (wr_en && int'(wr_chan) == c && int'(wr_slot) == s)
          words[c][s] <= wr_data;
      end
    end
    assign chan_en[c]  = words[c][SLOT_CONF][CONF_EN_BIT];
    assign tc_mask[c]  = words[c][SLOT_CONF][CONF_TCM_BIT];
    assign err_mask[c] = words[c][SLOT_CONF][CONF_ERM_BIT];
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < NSLOT; s++)
        if (int'(rd_chan) == c && int'(rd_slot) == s)
          rd_data = words[c][s];
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  input  logic [NCH-1:0] tc_clr,
  input  logic [NCH-1:0] err_clr,
  input  logic [NCH-1:0] tc_mask,
  input  logic [NCH-1:0] err_mask,
  output logic [NCH-1:0] tc_raw,
  output logic [NCH-1:0] err_raw,
  output logic           irq_tc,
  output logic           irq_err,
  output logic           irq_any
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_raw  <= '0;
      err_raw <= '0;
      irq_tc  <= 1'b0;
      irq_err <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      // a set pulse beats a clear of the same bit
      tc_raw  <= (tc_raw & ~tc_clr) | tc_set;
      err_raw <= (err_raw & ~err_clr) | err_set;
      irq_tc  <= |(tc_raw & tc_mask);
      irq_err <= |(err_raw & err_mask);
      irq_any <= |(tc_raw & tc_mask) | |(err_raw & err_mask);
    end
  end
endmodule

// File: rtl/dma_regblk.sv
module dma_regblk
  import dma_regblk_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [11:0]    bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           bus_rvalid,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  output logic [NCH-1:0] chan_en,
  output logic           ctrl_en,
  output logic           kick,
  output logic           irq_err,
  output logic           irq_tc,
  output logic           irq_any
);
  localparam int PAD = DW - NCH;

  logic [9:0]    word;
  logic [2:0]    chan, slot;
  logic          is_chan, chan_ok, is_glob, is_id, wr, rd;
  logic [DW-1:0] gconf_q, sync_q, bank_rd, rd_next;
  logic [NCH-1:0] tc_mask, err_mask, tc_raw, err_raw, tc_clr, err_clr;
  logic [NCH-1:0] tc_msk, er_msk;
  logic          unused_addr;

  assign unused_addr = ^bus_addr[1:0];
  assign word    = bus_addr[11:2];
  assign chan    = bus_addr[7:5];
  assign slot    = bus_addr[4:2];
  assign is_chan = bus_addr[11:8] == 4'h1;
  assign chan_ok = is_chan && (int'(chan) < NCH) && (int'(slot) < NSLOT);
  assign is_glob = bus_addr[11:8] == 4'h0;
  assign is_id   = bus_addr[11:5] == 7'h7F;
  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;

  dma_chan_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr && chan_ok), .wr_chan(chan), .wr_slot(slot), .wr_data(bus_wdata),
    .rd_chan(chan), .rd_slot(slot), .rd_data(bank_rd),
    .chan_en(chan_en), .tc_mask(tc_mask), .err_mask(err_mask)
  );

  assign tc_clr  = (wr && is_glob && word == GW_TC_CLR) ? bus_wdata[NCH-1:0] : '0;
  assign err_clr = (wr && is_glob && word == GW_ER_CLR) ? bus_wdata[NCH-1:0] : '0;

  dma_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst),
    .tc_set(tc_set), .err_set(err_set), .tc_clr(tc_clr), .err_clr(err_clr),
    .tc_mask(tc_mask), .err_mask(err_mask),
    .tc_raw(tc_raw), .err_raw(err_raw),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  assign tc_msk = tc_raw & tc_mask;
  assign er_msk = err_raw & err_mask;

  always_comb begin
    rd_next = '0;
    if (chan_ok)
      rd_next = bank_rd;
    else if (is_id)
      rd_next = {24'h0, id_byte(bus_addr[4:2], NCH)};
    else if (is_glob) begin
      case (word)
        GW_STAT:    rd_next = {{PAD{1'b0}}, tc_msk | er_msk};
        GW_TC_STAT: rd_next = {{PAD{1'b0}}, tc_msk};
        GW_ER_STAT: rd_next = {{PAD{1'b0}}, er_msk};
        GW_TC_RAW:  rd_next = {{PAD{1'b0}}, tc_raw};
        GW_ER_RAW:  rd_next = {{PAD{1'b0}}, err_raw};
        GW_ENMAP:   rd_next = {{PAD{1'b0}}, chan_en};
        GW_GCONF:   rd_next = gconf_q;
        GW_SYNC:    rd_next = sync_q;
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gconf_q    <= '0;
      sync_q     <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      kick       <= 1'b0;
    end else begin
      if (wr && is_glob && word == GW_GCONF) gconf_q <= bus_wdata;
      if (wr && is_glob && word == GW_SYNC)  sync_q  <= bus_wdata;
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_next;
      kick <= wr && ((chan_ok && slot == SLOT_CONF) || (is_glob && word == GW_GCONF));
    end
  end

  assign ctrl_en = gconf_q[0];
endmodule

// File: rtl/dma_regblk_chk.sv
module dma_regblk_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_valid,
  input logic           bus_write,
  input logic [11:0]    bus_addr,
  input logic [31:0]    bus_rdata,
  input logic           bus_rvalid,
  input logic [NCH-1:0] tc_set,
  input logic [NCH-1:0] tc_raw,
  input logic           kick,
  input logic           irq_err,
  input logic           irq_tc,
  input logic           irq_any
);
  assert_kick_source_R10: assert property (@(posedge clk) disable iff (rst)
    kick |-> $past(bus_valid && bus_write &&
      ((bus_addr[11:8] == 4'h1 && bus_addr[4:2] == 3'd4 && int'(bus_addr[7:5]) < NCH) ||
       bus_addr[11:2] == 10'd12)));

  assert_read_response_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_id_word_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr == 12'hFE4) |=> bus_rdata == 32'h10);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr >= 12'h200 && bus_addr < 12'hFE0) |=> bus_rdata == '0);

  assert_soft_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr[11:4] == 8'h02) |=> bus_rdata == '0);

  assert_set_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (|tc_set) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

  assert_any_is_or_R7: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_err || irq_tc));
endmodule

bind dma_regblk dma_regblk_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_regblk_tb.sv
module dma_regblk_tb;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NCH-1:0] tc_set = '0, err_set = '0;
  logic [NCH-1:0] chan_en;
  logic ctrl_en, kick, irq_err, irq_tc, irq_any;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_regblk #(.NCH(NCH)) u_dut (.*);

  // monitor: compare read responses against scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL rvalid with no expected read: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic bus_op(input logic v, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [NCH-1:0] ts,
                        input logic [NCH-1:0] es);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    tc_set = ts; err_set = es;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tc_set = '0; err_set = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_op(1'b1, 1'b1, a, d, '0, '0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_op(1'b1, 1'b0, a, '0, '0, '0);
  endtask

  function automatic logic [11:0] ca(input int c, input int s);
    return 12'(12'h100 + c * 32 + s * 4);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_any", {31'b0, irq_any}, 0);
    chk("R1 irq_tc", {31'b0, irq_tc}, 0);
    chk("R1 kick", {31'b0, kick}, 0);
    chk("R1 chan_en", {24'b0, chan_en}, 0);
    rd(12'h000, 0, "R1 status");
    rd(12'h014, 0, "R1 raw tc");
    rd(12'h030, 0, "R1 gconf");
    rd(ca(5, 4), 0, "R1 chan conf");

    // R2 channel words
    wr(ca(3, 0), 32'hA5A5_0001);
    wr(ca(1, 1), 32'h1234_5678);
    wr(ca(5, 2), 32'hDEAD_BEEF);
    wr(ca(0, 3), 32'h0F0F_F0F0);
    wr(ca(0, 0), 32'h0000_0100);
    rd(ca(3, 0), 32'hA5A5_0001, "R2 ch3 src");
    rd(ca(1, 1), 32'h1234_5678, "R2 ch1 dst");
    rd(ca(5, 2), 32'hDEAD_BEEF, "R2 ch5 link");
    rd(ca(0, 3), 32'h0F0F_F0F0, "R2 ch0 ctrl");
    chk("R10 no kick on src write", {31'b0, kick}, 0);

    // R10 + R8: channel config write
    wr(ca(7, 4), 32'h0000_0001);
    chk("R10 kick after conf write", {31'b0, kick}, 1);
    chk("R8 chan_en", {24'b0, chan_en}, 32'h80);
    @(negedge clk);
    chk("R10 kick single cycle", {31'b0, kick}, 0);
    rd(12'h01C, 32'h80, "R8 enabled map");
    wr(12'h030, 32'h0000_0005);
    chk("R10 kick after gconf write", {31'b0, kick}, 1);
    chk("R8 ctrl_en", {31'b0, ctrl_en}, 1);
    wr(12'h034, 32'hCAFE_0042);
    chk("R10 no kick on sync write", {31'b0, kick}, 0);
    rd(12'h030, 32'h5, "R8 gconf");
    rd(12'h034, 32'hCAFE_0042, "R8 sync");

    // R3 invalid offsets
    wr(ca(0, 5), 32'hFFFF_FFFF);
    rd(ca(0, 5), 0, "R3 slot5 read");
    rd(ca(0, 0), 32'h100, "R3 slot5 write ignored");
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, 0, "R3 hole read");
    rd(12'h03C, 0, "R3 unused global");
    rd(ca(7, 4), 32'h1, "R3 conf intact");

    // R11 software request words
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h020, 0, "R11 soft 0x020");
    rd(12'h024, 0, "R11 soft 0x024");
    rd(12'h02C, 0, "R11 soft 0x02C");

    // R9 identification
    rd(12'hFE0, 32'h80, "R9 id0");
    rd(12'hFE4, 32'h10, "R9 id1");
    rd(12'hFEC, 32'h0A, "R9 id3");
    rd(12'hFFC, 32'hB1, "R9 id7");

    // R4/R6/R7 set pulses and masks
    wr(ca(2, 4), 32'h0000_8000);
    bus_op(1'b0, 1'b0, 12'h0, 0, 8'h14, 8'h00);
    @(negedge clk);
    chk("R7 irq_tc", {31'b0, irq_tc}, 1);
    chk("R7 irq_any", {31'b0, irq_any}, 1);
    chk("R7 irq_err low", {31'b0, irq_err}, 0);
    rd(12'h014, 32'h14, "R4 raw tc");
    rd(12'h004, 32'h04, "R6 masked tc");
    bus_op(1'b0, 1'b0, 12'h0, 0, 8'h00, 8'h10);
    @(negedge clk);
    chk("R6 unmasked error no irq", {31'b0, irq_err}, 0);
    rd(12'h018, 32'h10, "R4 raw err");
    rd(12'h00C, 32'h00, "R6 masked err off");
    wr(ca(4, 4), 32'h0000_4000);
    @(negedge clk);
    chk("R7 irq_err after mask", {31'b0, irq_err}, 1);
    rd(12'h00C, 32'h10, "R6 masked err on");
    rd(12'h000, 32'h14, "R6 combined");

    // R5 clears
    wr(12'h008, 32'h0000_0004);
    @(negedge clk);
    chk("R5 irq_tc cleared", {31'b0, irq_tc}, 0);
    rd(12'h014, 32'h10, "R5 raw tc after clear");
    bus_op(1'b1, 1'b1, 12'h008, 32'h10, 8'h10, 8'h00);
    rd(12'h014, 32'h10, "R5 set beats clear");
    wr(12'h010, 32'h0000_0010);
    @(negedge clk);
    chk("R5 irq_err cleared", {31'b0, irq_err}, 0);
    chk("R7 irq_any low", {31'b0, irq_any}, 0);
    rd(12'h018, 0, "R5 raw err cleared");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule